// File: doc/BRIEF.md
# Reloadable Down-Counter Timer Bank

The block holds five down-counting timer channels behind a 32-bit register port. Software fills a per-channel count buffer. It copies the buffer into the live counter with a rising edge on the channel's manual-update control bit, and starts or stops the channel with edges on its start bit. While a channel runs, every strobe on its tick input lowers the count by one. An external prescaler supplies the ticks.

A tick that arrives while a running counter is already at zero is an expiry. On expiry the channel latches a status flag and, if enabled, raises its level interrupt line. The counter then either reloads from its buffer and keeps running, or stops and clears its own start bit. Channels 0 to 3 also have a compare buffer and drive a PWM output built from the live count. Channel 4 has neither, and its auto-reload bit sits apart from the regular four-bit group.

Top module: `dcnt_bank`

## Requirements
- R1: The port is byte addressed, with word-aligned 32-bit accesses. Config words are at 0x00 (reset 0x00000101) and 0x04 (reset 0), and control is at 0x08. Channel n < 4 has its count buffer at 0x0C+12n, its compare buffer at 0x10+12n and its live-count view at 0x14+12n. Channel 4 has its count buffer at 0x3C and its live-count view at 0x40. The interrupt word is at 0x44. Any other offset, or any address with bits [1:0] not zero, reads as 0 and a write to it changes nothing.
- R2: In the control word, channel 0 uses bits 0..3 and channel n in 1..3 uses bits 4+4n..7+4n, ordered start, manual update, invert, auto-reload. Channel 4 has start at bit 20, manual update at 21 and auto-reload at 22. All other bits read back as 0, so writing all ones reads back 0x007FFF0F.
- R3: A control write that moves a channel's manual-update bit from 0 to 1 copies its count buffer into the live counter. A write that leaves the bit at 1 loads nothing.
- R4: A channel runs while its start bit is 1. Each tick strobe decrements the live count of a running channel, and a stopped channel ignores ticks. When one write raises both manual update and start, the loaded value is the one that counts.
- R5: A tick on a running channel whose count is 0 is an expiry and sets status bit 5+n of the interrupt word. Without auto-reload, the count stays 0 and the hardware clears the channel's start bit. A buffer value N therefore expires on tick N+1.
- R6: With auto-reload set, an expiry reloads the count buffer and the channel keeps running, with start still at 1.
- R7: An expiry raises interrupt line n only when enable bit n (interrupt word bit n) is 1. The line then stays high.
- R8: A write to the interrupt word replaces enables [4:0]. A 1 in bit 5+n clears status n and lowers line n. A 0 there leaves the status as it is.
- R9: PWM output n (n < 4) is high while the channel runs and its live count is at or below the compare buffer, and low otherwise. The invert bit flips the output, including while the channel is stopped.
- R10: Reset clears the control word, the interrupt word, all buffers and all live counts. After reset the interrupt lines and PWM outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_i | input | 5 | Per-channel count strobes from the prescaler |
| irq_o | output | 5 | Per-channel level interrupt lines |
| pwm_o | output | 4 | PWM outputs of channels 0 to 3 |

## Verification
The bench builds the block with the default 32-bit counter width. Random values across the full width test buffer storage and readback, while the count buffers used for running stay at single digits. With such small buffers, expiry, one-shot stop and auto-reload wrap all occur within a few ticks. Random buffer lengths, tick counts, reload modes and enables across all five channels reach both sides of the N+1 expiry boundary. The irregular channel 4 control layout is reached the same way.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
    localparam int NCH  = 5;
    localparam int NOUT = 4;

    localparam logic [7:0] OFS_CFG0 = 8'h00;
    localparam logic [7:0] OFS_CFG1 = 8'h04;
    localparam logic [7:0] OFS_CTRL = 8'h08;
    localparam logic [7:0] OFS_IRQ  = 8'h44;

    // Group base in the control word; channel 0 is packed at the bottom.
    function automatic int ctl_base(int n);
        return (n == 0) ? 0 : 4 + 4 * n;
    endfunction

    function automatic int start_pos(int n);
        return ctl_base(n);
    endfunction

    function automatic int upd_pos(int n);
        return ctl_base(n) + 1;
    endfunction

    function automatic int inv_pos(int n);
        return ctl_base(n) + 2;
    endfunction

    // Channel 4 has no invert bit, so its reload bit takes that slot.
    function automatic int rel_pos(int n);
        return (n == NCH - 1) ? 22 : ctl_base(n) + 3;
    endfunction

    function automatic logic [31:0] ctrl_mask();
        logic [31:0] m;
        m = '0;
        for (int n = 0; n < NCH; n++) begin
            m[start_pos(n)] = 1'b1;
            m[upd_pos(n)]   = 1'b1;
            m[rel_pos(n)]   = 1'b1;
            if (n < NOUT) m[inv_pos(n)] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [7:0] cnt_ofs(int n);
        return 8'(12 + 12 * n);
    endfunction

    function automatic logic [7:0] cmp_ofs(int n);
        return 8'(16 + 12 * n);
    endfunction

    function automatic logic [7:0] obs_ofs(int n);
        return (n == NCH - 1) ? 8'h40 : 8'(20 + 12 * n);
    endfunction
endpackage

// File: rtl/dcnt_chan.sv
module dcnt_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] buf_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = run_i && tick_i && (st_q.count == '0);
        if (load_i) begin
            st_d.count = buf_i;
        end else if (expire_o) begin
            if (reload_i) st_d.count = buf_i;
        end else if (run_i && tick_i) begin
            st_d.count = st_q.count - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
endmodule

// File: rtl/dcnt_irq.sv
module dcnt_irq #(
    parameter int N = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [2*N-1:0] wdata_i,
    input  logic [N-1:0]   expire_i,
    output logic [N-1:0]   en_o,
    output logic [N-1:0]   stat_o,
    output logic [N-1:0]   irq_o
);
    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] stat;
        logic [N-1:0] line;
    } irq_st_t;

    irq_st_t      st_d, st_q;
    logic [N-1:0] clr;

    always_comb begin
        st_d = st_q;
        clr  = wr_i ? wdata_i[2*N-1:N] : '0;
        if (wr_i) st_d.en = wdata_i[N-1:0];
        // A fresh expiry wins over a clear in the same cycle.
        st_d.stat = (st_q.stat & ~clr) | expire_i;
        st_d.line = (st_q.line & ~clr) | (expire_i & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign stat_o = st_q.stat;
    assign irq_o  = st_q.line;
endmodule

// File: rtl/dcnt_pwm.sv
module dcnt_pwm #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             run_i,
    input  logic             inv_i,
    output logic             pwm_o
);
    logic raw;

    always_comb begin
        raw   = run_i && (count_i <= cmp_i);
        pwm_o = raw ^ inv_i;
    end
endmodule

// File: rtl/dcnt_bank.sv
module dcnt_bank
    import dcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NCH-1:0]  tick_i,
    output logic [NCH-1:0]  irq_o,
    output logic [NOUT-1:0] pwm_o
);
    localparam logic [31:0] CMASK    = ctrl_mask();
    localparam logic [31:0] CFG0_RST = 32'h0000_0101;

    typedef struct packed {
        logic [31:0]                 cfg0;
        logic [31:0]                 cfg1;
        logic [31:0]                 ctrl;
        logic [NCH-1:0][CNT_W-1:0]   cntbuf;
        logic [NOUT-1:0][CNT_W-1:0]  cmpbuf;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic                      aligned;
    logic                      ctrl_wr;
    logic                      irq_wr;
    logic [NCH-1:0]            run_w;
    logic [NCH-1:0]            rel_w;
    logic [NCH-1:0]            load_w;
    logic [NCH-1:0]            expire_w;
    logic [NOUT-1:0]           inv_w;
    logic [NCH-1:0][CNT_W-1:0] count_w;
    logic [NCH-1:0]            en_w;
    logic [NCH-1:0]            stat_w;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign ctrl_wr = bus_wr && aligned && (bus_addr == OFS_CTRL);
    assign irq_wr  = bus_wr && aligned && (bus_addr == OFS_IRQ);

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        localparam int SP = start_pos(n);
        localparam int UP = upd_pos(n);
        localparam int RP = rel_pos(n);

        assign run_w[n]  = st_q.ctrl[SP];
        assign rel_w[n]  = st_q.ctrl[RP];
        assign load_w[n] = ctrl_wr && bus_wdata[UP] && !st_q.ctrl[UP];

        dcnt_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i[n]),
            .run_i    (run_w[n]),
            .load_i   (load_w[n]),
            .reload_i (rel_w[n]),
            .buf_i    (st_q.cntbuf[n]),
            .count_o  (count_w[n]),
            .expire_o (expire_w[n])
        );
    end

    for (genvar n = 0; n < NOUT; n++) begin : g_pwm
        localparam int IP = inv_pos(n);

        assign inv_w[n] = st_q.ctrl[IP];

        dcnt_pwm #(.CNT_W(CNT_W)) u_pwm (
            .count_i (count_w[n]),
            .cmp_i   (st_q.cmpbuf[n]),
            .run_i   (run_w[n]),
            .inv_i   (inv_w[n]),
            .pwm_o   (pwm_o[n])
        );
    end

    dcnt_irq #(.N(NCH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (irq_wr),
        .wdata_i  (bus_wdata[2*NCH-1:0]),
        .expire_i (expire_w),
        .en_o     (en_w),
        .stat_o   (stat_w),
        .irq_o    (irq_o)
    );

    // Next-state: hardware stop of one-shot channels, then the bus write.
    always_comb begin
        st_d = st_q;
        for (int n = 0; n < NCH; n++) begin
            if (expire_w[n] && !rel_w[n]) st_d.ctrl[start_pos(n)] = 1'b0;
        end
        if (bus_wr && aligned) begin
            case (bus_addr)
                OFS_CFG0: st_d.cfg0 = bus_wdata;
                OFS_CFG1: st_d.cfg1 = bus_wdata;
                OFS_CTRL: st_d.ctrl = bus_wdata & CMASK;
                default: ;
            endcase
            for (int n = 0; n < NCH; n++) begin
                if (bus_addr == cnt_ofs(n)) st_d.cntbuf[n] = bus_wdata[CNT_W-1:0];
            end
            for (int n = 0; n < NOUT; n++) begin
                if (bus_addr == cmp_ofs(n)) st_d.cmpbuf[n] = bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cfg0 <= CFG0_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (bus_addr)
                OFS_CFG0: bus_rdata = st_q.cfg0;
                OFS_CFG1: bus_rdata = st_q.cfg1;
                OFS_CTRL: bus_rdata = st_q.ctrl;
                OFS_IRQ:  bus_rdata = 32'({stat_w, en_w});
                default: ;
            endcase
            for (int n = 0; n < NCH; n++) begin
                if (bus_addr == cnt_ofs(n)) bus_rdata = 32'(st_q.cntbuf[n]);
                if (bus_addr == obs_ofs(n)) bus_rdata = 32'(count_w[n]);
            end
            for (int n = 0; n < NOUT; n++) begin
                if (bus_addr == cmp_ofs(n)) bus_rdata = 32'(st_q.cmpbuf[n]);
            end
        end
    end
endmodule

// File: rtl/dcnt_bank_chk.sv
module dcnt_bank_chk
    import dcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ctrl_wr,
    input logic [NCH-1:0]            run,
    input logic [NCH-1:0]            rel,
    input logic [NCH-1:0]            load,
    input logic [NCH-1:0]            expire,
    input logic [NCH-1:0][CNT_W-1:0] count,
    input logic [NCH-1:0][CNT_W-1:0] cntbuf,
    input logic [NCH-1:0]            stat,
    input logic [NCH-1:0]            irq,
    input logic [NOUT-1:0]           inv,
    input logic [NOUT-1:0]           pwm
);
    AST_LINE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~stat) == '0); // R8

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        AST_LOAD_COPIES_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
            load[n] |=> count[n] == $past(cntbuf[n])); // R3

        AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[n] && !load[n]) |=> $stable(count[n])); // R4

        AST_EXPIRY_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
            expire[n] |=> stat[n]); // R5

        AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[n] && !rel[n] && !ctrl_wr) |=> !run[n]); // R5

        AST_RELOAD_FROM_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[n] && rel[n] && !load[n]) |=> count[n] == $past(cntbuf[n])); // R6
    end

    for (genvar n = 0; n < NOUT; n++) begin : g_out
        AST_PWM_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            !run[n] |-> pwm[n] == inv[n]); // R9
    end
endmodule

bind dcnt_bank dcnt_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .run     (run_w),
    .rel     (rel_w),
    .load    (load_w),
    .expire  (expire_w),
    .count   (count_w),
    .cntbuf  (st_q.cntbuf),
    .stat    (stat_w),
    .irq     (irq_o),
    .inv     (inv_w),
    .pwm     (pwm_o)
);

// File: tb/dcnt_bank_bench.sv
module dcnt_bank_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tick_i = '0;
    logic [4:0]  irq_o;
    logic [3:0]  pwm_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #(CLK_P/2) clk = ~clk;

    dcnt_bank u_dcnt_bank (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .tick_i (tick_i),
        .irq_o (irq_o), .pwm_o (pwm_o)
    );

    function automatic int b_base(int n);  return (n == 0) ? 0 : 4 + 4 * n; endfunction
    function automatic int b_start(int n); return b_base(n); endfunction
    function automatic int b_upd(int n);   return b_base(n) + 1; endfunction
    function automatic int b_inv(int n);   return b_base(n) + 2; endfunction
    function automatic int b_rel(int n);   return (n == 4) ? 22 : b_base(n) + 3; endfunction
    function automatic logic [7:0] a_cnt(int n); return 8'(12 + 12 * n); endfunction
    function automatic logic [7:0] a_cmp(int n); return 8'(16 + 12 * n); endfunction
    function automatic logic [7:0] a_obs(int n); return (n == 4) ? 8'h40 : 8'(20 + 12 * n); endfunction

    function automatic logic [31:0] exp_count(int nv, int k, bit rl);
        if (rl) return 32'(nv - (k % (nv + 1)));
        return (k > nv) ? 32'd0 : 32'(nv - k);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tk(logic [4:0] m, int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); tick_i = m;
            @(negedge clk); tick_i = '0;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        rd(8'h00, rv); chk("R10 cfg0", rv, 32'h101);
        rd(8'h04, rv); chk("R10 cfg1", rv, 0);
        rd(8'h08, rv); chk("R10 ctrl", rv, 0);
        rd(8'h44, rv); chk("R10 irq word", rv, 0);
        for (int n = 0; n < 5; n++) begin
            rd(a_cnt(n), rv); chk("R10 count buffer", rv, 0);
            rd(a_obs(n), rv); chk("R10 live count", rv, 0);
        end
        for (int n = 0; n < 4; n++) begin
            rd(a_cmp(n), rv); chk("R10 compare buffer", rv, 0);
        end
        chk("R10 irq lines", 32'(irq_o), 0);
        chk("R10 pwm", 32'(pwm_o), 0);

        // R1: random buffer storage and readback
        for (int i = 0; i < 12; i++) begin
            int n = $urandom_range(0, 4);
            logic [31:0] d = $urandom;
            wr(a_cnt(n), d); rd(a_cnt(n), rv); chk("R1 count buffer", rv, d);
            if (n < 4) begin
                d = $urandom;
                wr(a_cmp(n), d); rd(a_cmp(n), rv); chk("R1 compare buffer", rv, d);
            end
        end
        wr(8'h04, 32'hA5A5_0F0F); rd(8'h04, rv); chk("R1 cfg1", rv, 32'hA5A5_0F0F);
        wr(8'h48, 32'hFFFF_FFFF); rd(8'h48, rv); chk("R1 unmapped read", rv, 0);
        wr(8'h01, 32'hDEAD_BEEF); rd(8'h00, rv); chk("R1 misaligned write ignored", rv, 32'h101);
        rd(8'h02, rv); chk("R1 misaligned read", rv, 0);

        // R2: control mask
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, rv); chk("R2 ctrl mask", rv, 32'h007F_FF0F);
        wr(8'h08, 0);

        // R3: manual update on rising edge only
        wr(a_cnt(0), 5);
        wr(8'h08, 32'h2); rd(a_obs(0), rv); chk("R3 load on edge", rv, 5);
        wr(a_cnt(0), 9);
        wr(8'h08, 32'h2); rd(a_obs(0), rv); chk("R3 no load at level", rv, 5);

        // R4: counting and stopping
        wr(8'h08, 32'h3); tk(5'h1F, 3);
        rd(a_obs(0), rv); chk("R4 decrement", rv, 2);
        wr(8'h08, 32'h2); tk(5'h1F, 2);
        rd(a_obs(0), rv); chk("R4 stopped ignores ticks", rv, 2);
        wr(8'h08, 0);
        wr(a_cnt(2), 4);
        wr(8'h08, (32'h1 << b_upd(2)) | (32'h1 << b_start(2)));
        rd(a_obs(2), rv); chk("R4 load then start", rv, 4);
        tk(5'h04, 1); rd(a_obs(2), rv); chk("R4 counts loaded value", rv, 3);
        wr(8'h08, 0);

        // R6 / R7 / R8: channel 4 auto-reload with interrupt
        wr(8'h44, 32'h3E0 | 32'h10);
        wr(a_cnt(4), 2);
        wr(8'h08, (32'h1 << 21) | (32'h1 << 22));
        wr(8'h08, (32'h1 << 20) | (32'h1 << 21) | (32'h1 << 22));
        tk(5'h10, 3);
        rd(a_obs(4), rv); chk("R6 reload value", rv, 2);
        rd(8'h08, rv); chk("R6 start kept", 32'(rv[20]), 1);
        rd(8'h44, rv); chk("R5 status bit 9", 32'(rv[9]), 1);
        chk("R7 line raised", 32'(irq_o[4]), 1);
        wr(8'h44, 32'h10);
        rd(8'h44, rv); chk("R8 zero leaves status", rv, 32'h210);
        chk("R8 line kept", 32'(irq_o[4]), 1);
        wr(8'h44, 32'h200 | 32'h10);
        rd(8'h44, rv); chk("R8 status cleared", rv, 32'h10);
        chk("R8 line lowered", 32'(irq_o[4]), 0);
        wr(8'h08, 0);

        // R9: PWM on channel 1
        wr(8'h44, 32'h3E0);
        wr(a_cmp(1), 3); wr(a_cnt(1), 6);
        wr(8'h08, (32'h1 << b_upd(1)) | (32'h1 << b_rel(1)));
        chk("R9 stopped low", 32'(pwm_o[1]), 0);
        wr(8'h08, (32'h1 << b_upd(1)) | (32'h1 << b_rel(1)) | (32'h1 << b_start(1)));
        #1 chk("R9 above compare low", 32'(pwm_o[1]), 0);
        tk(5'h02, 3);
        #1 chk("R9 at compare high", 32'(pwm_o[1]), 1);
        wr(8'h08, (32'h1 << b_upd(1)) | (32'h1 << b_rel(1)) | (32'h1 << b_start(1)) | (32'h1 << b_inv(1)));
        #1 chk("R9 inverted", 32'(pwm_o[1]), 0);
        wr(8'h08, (32'h1 << b_upd(1)) | (32'h1 << b_inv(1)));
        #1 chk("R9 stopped inverted", 32'(pwm_o[1]), 1);
        wr(8'h08, 0);

        // R4 / R5 / R6 / R7: random lengths, modes and enables
        for (int i = 0; i < 24; i++) begin
            int n  = $urandom_range(0, 4);
            int nv = $urandom_range(0, 6);
            int k  = $urandom_range(0, 15);
            bit rl = 1'($urandom_range(0, 1));
            bit en = 1'($urandom_range(0, 1));
            bit ex;
            logic [31:0] cw;
            wr(8'h08, 0);
            wr(8'h44, 32'h3E0 | (32'(en) << n));
            wr(a_cnt(n), 32'(nv));
            cw = (32'h1 << b_upd(n)) | (rl ? (32'h1 << b_rel(n)) : 32'h0);
            wr(8'h08, cw);
            wr(8'h08, cw | (32'h1 << b_start(n)));
            tk(5'h1F, k);
            ex = (k > nv);
            rd(a_obs(n), rv); chk(rl ? "R6 random count" : "R4 random count", rv, exp_count(nv, k, rl));
            rd(8'h44, rv);    chk("R5 random status", 32'(rv[5 + n]), 32'(ex));
            chk("R7 random line", 32'(irq_o[n]), 32'(ex && en));
            rd(8'h08, rv);    chk("R5 random start bit", 32'(rv[b_start(n)]), 32'(rl || !ex));
        end
        wr(8'h08, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule